// File: doc/BRIEF.md
# Chip Reset and Trap Vector Controller

This block sits beside the processor clock generator. It watches four urgent error inputs (control error, bus error on a nonexistent memory location, read parity error, memory-management abort) and a power-low indicator. When one of them needs attention, it raises a chip-reset pulse shortly after the processor clock enters its low phase. The clock generator uses that pulse to stretch the low phase. The block also hands the processor the trap vector it must take.

The block runs on the high-frequency tick clock. `phase_low` comes from the clock generator, changes just after a tick edge, and is high during the low phase of the processor clock. The reset output `chip_rst` fans out to every chip of the set except the memory-management unit, which must not be wired to it.

The trap vector leaves on a valid/ready stream. `trap_vec` is offered with `trap_valid` high and is held stable until a tick edge on which `trap_ready` is also high. While a vector waits unaccepted, the block starts no further reset, so that a pending trap is never overwritten. Power-up resets carry no vector.

Top module: `rst_trap_ctrl`

## Requirements
- R1: After `rst_n` is released, `chip_rst` and `trap_valid` are low, and they stay low until a service is started.
- R2: `chip_rst` rises only on the first tick edge at which `phase_low` is sampled high, and only when a condition is waiting. It then stays high for exactly `PULSE_TICKS` ticks (2 by default).
- R3: A falling edge of `dc_low` while out of reset arms exactly two power-up resets. These are served on two consecutive low phases. They raise no `trap_valid`, and `dc_low` going high again cancels any not yet served.
- R4: Each error condition drives a 9-bit `trap_vec`: control error octal 010, bus error octal 004, parity error octal 114, and memory-management abort octal 250.
- R5: When several conditions are waiting at the same low-phase start, the order is power-up, control, bus, parity, abort. Only the winner is served, and every error flag waiting at that moment is discarded.
- R6: Each error input is captured on its rising edge and held until a low phase serves it. An input held high produces only one service.
- R7: While `trap_valid` is high and `trap_ready` is low, `trap_valid` stays high and `trap_vec` does not change. `trap_valid` falls on the tick edge after a handshake.
- R8: While `trap_valid` is high, no new `chip_rst` starts. A condition that arrives in that time stays waiting and is served at the first low phase after the vector is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-frequency tick clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_err | input | 1 | Nonexistent control chip selected |
| bus_err | input | 1 | Nonexistent memory location accessed |
| par_err | input | 1 | Parity error on a memory read |
| mmu_abort | input | 1 | Memory-management abort of a mapped reference |
| dc_low | input | 1 | DC power low; its falling edge means power-up |
| phase_low | input | 1 | High while the processor clock is in its low phase |
| trap_ready | input | 1 | Consumer accepts `trap_vec` |
| chip_rst | output | 1 | Reset pulse to all chips except the MMU |
| trap_valid | output | 1 | `trap_vec` holds a vector to be taken |
| trap_vec | output | 9 | Trap vector code |

## Verification
The bench targets the power-up count: a design that issues one reset, or three, is caught by counting pulses over three low phases. Colliding errors and an error held high are applied. A wrong priority shows up as a wrong vector, and a level-triggered capture shows up as a second reset. The back-pressure case leaves a vector unaccepted while a new error arrives. A design that resets anyway, or that loses the waiting error, shows a pulse at the wrong low phase or none at the right one.

// File: rtl/rst_trap_pkg.sv
package rst_trap_pkg;
  localparam int NSRC  = 4;
  localparam int VEC_W = 9;
  // source index doubles as priority rank (0 = highest among errors)
  localparam int SRC_CTL = 0;
  localparam int SRC_BUS = 1;
  localparam int SRC_PAR = 2;
  localparam int SRC_MMU = 3;

  function automatic logic [VEC_W-1:0] vec_of(input int idx);
    case (idx)
      SRC_CTL: vec_of = 9'o010;
      SRC_BUS: vec_of = 9'o004;
      SRC_PAR: vec_of = 9'o114;
      default: vec_of = 9'o250;
    endcase
  endfunction
endpackage

// File: rtl/rt_capture.sv
module rt_capture #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  input  logic         clr,
  output logic [N-1:0] pend
);
  logic [N-1:0] lvl_q;

  for (genvar i = 0; i < N; i++) begin : g_cap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lvl_q[i] <= 1'b0;
        pend[i]  <= 1'b0;
      end else begin
        lvl_q[i] <= lvl[i];
        // a fresh edge wins over a clear on the same tick
        pend[i]  <= (pend[i] & ~clr) | (lvl[i] & ~lvl_q[i]);
      end
    end
  end

  // R6: a held level never re-arms a served flag
  assert_no_rearm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && lvl_q == lvl && lvl == {N{1'b1}}) |=> pend == '0);
endmodule

// File: rtl/rt_prio.sv
module rt_prio
  import rst_trap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_pend,
  input  logic [NSRC-1:0]   err_pend,
  output logic              any,
  output logic              win_pwr,
  output logic [VEC_W-1:0]  win_vec
);
  logic [NSRC-1:0] sel;

  always_comb begin
    sel = '0;
    if (!pwr_pend) begin
      for (int i = NSRC-1; i >= 0; i--) begin
        if (err_pend[i]) sel = '0;
        if (err_pend[i]) sel[i] = 1'b1;
      end
    end
  end

  always_comb begin
    win_vec = '0;
    for (int i = 0; i < NSRC; i++)
      if (sel[i]) win_vec = vec_of(i);
  end

  assign win_pwr = pwr_pend;
  assign any     = pwr_pend | (|err_pend);

  // R5: exactly one winner whenever anything waits
  assert_one_winner_R5: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> $countones({win_pwr, sel}) == 1);
endmodule

// File: rtl/rt_pulse.sv
module rt_pulse #(
  parameter int PULSE_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic pulse
);
  localparam int CW = $clog2(PULSE_TICKS + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= CW'(PULSE_TICKS);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign pulse = (cnt != '0);

  // R2: a new service never starts inside a running pulse
  assert_no_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !pulse);
endmodule

// File: rtl/rst_trap_ctrl.sv
module rst_trap_ctrl
  import rst_trap_pkg::*;
#(
  parameter int PULSE_TICKS = 2,
  parameter int PWR_RESETS  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_err,
  input  logic             bus_err,
  input  logic             par_err,
  input  logic             mmu_abort,
  input  logic             dc_low,
  input  logic             phase_low,
  input  logic             trap_ready,
  output logic             chip_rst,
  output logic             trap_valid,
  output logic [VEC_W-1:0] trap_vec
);
  localparam int PW = $clog2(PWR_RESETS + 1);

  logic [NSRC-1:0]  err_lvl, err_pend;
  logic             phase_q, dc_q, start, any, win_pwr;
  logic [VEC_W-1:0] win_vec;
  logic [PW-1:0]    pwr_cnt;

  assign err_lvl[SRC_CTL] = ctl_err;
  assign err_lvl[SRC_BUS] = bus_err;
  assign err_lvl[SRC_PAR] = par_err;
  assign err_lvl[SRC_MMU] = mmu_abort;

  rt_capture #(.N(NSRC)) u_cap (
    .clk(clk), .rst_n(rst_n), .lvl(err_lvl), .clr(start), .pend(err_pend));

  rt_prio u_prio (
    .clk(clk), .rst_n(rst_n), .pwr_pend(pwr_cnt != '0), .err_pend(err_pend),
    .any(any), .win_pwr(win_pwr), .win_vec(win_vec));

  assign start = phase_low & ~phase_q & any & ~chip_rst & ~trap_valid;

  rt_pulse #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
    .clk(clk), .rst_n(rst_n), .start(start), .pulse(chip_rst));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      dc_q    <= 1'b1;
      pwr_cnt <= '0;
    end else begin
      phase_q <= phase_low;
      dc_q    <= dc_low;
      if (dc_low)                  pwr_cnt <= '0;
      else if (dc_q)               pwr_cnt <= PW'(PWR_RESETS);
      else if (start && win_pwr)   pwr_cnt <= pwr_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_valid <= 1'b0;
      trap_vec   <= '0;
    end else if (start && !win_pwr) begin
      trap_valid <= 1'b1;
      trap_vec   <= win_vec;
    end else if (trap_valid && trap_ready) begin
      trap_valid <= 1'b0;
    end
  end

  // R7: offered vector holds until taken
  assert_vec_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && !trap_ready) |=> (trap_valid && $stable(trap_vec)));
  // R2: reset only begins inside a low phase
  assert_rst_in_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chip_rst) |-> $past(phase_low));
  // R8: no reset starts while a vector waits
  assert_backpressure_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && !trap_ready) |=> !$rose(chip_rst));
  // R3: power-up service never offers a vector
  assert_pwr_no_trap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && win_pwr) |=> !$rose(trap_valid));
endmodule

// File: tb/sim_rst_trap_ctrl.sv
module sim_rst_trap_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_err = 0, bus_err = 0, par_err = 0, mmu_abort = 0;
  logic dc_low = 1, phase_low = 0, trap_ready = 0;
  logic chip_rst, trap_valid;
  logic [8:0] trap_vec;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  rst_trap_ctrl u0 (.*);

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one low phase of 3 ticks then 2 high ticks; returns ticks chip_rst seen high
  task automatic low_phase(output int hi);
    hi = 0;
    @(negedge clk) phase_low = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (chip_rst) hi++;
    end
    phase_low = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic accept();
    @(negedge clk) trap_ready = 1;
    @(negedge clk) trap_ready = 0;
  endtask

  task automatic t_reset();
    chk(!chip_rst, "R1 chip_rst", chip_rst, 0);
    chk(!trap_valid, "R1 trap_valid", trap_valid, 0);
  endtask

  task automatic t_powerup();
    int h;
    @(negedge clk) dc_low = 0;
    repeat (3) @(negedge clk);
    chk(!chip_rst, "R2 no reset outside low phase", chip_rst, 0);
    low_phase(h); chk(h == 2, "R3 first power reset width", h, 2);
    chk(!trap_valid, "R3 no trap on power", trap_valid, 0);
    low_phase(h); chk(h == 2, "R3 second power reset", h, 2);
    low_phase(h); chk(h == 0, "R3 no third reset", h, 0);
  endtask

  task automatic t_vec(input int which, input int exp);
    int h;
    @(negedge clk);
    case (which)
      0: ctl_err = 1; 1: bus_err = 1; 2: par_err = 1; default: mmu_abort = 1;
    endcase
    @(negedge clk) {ctl_err, bus_err, par_err, mmu_abort} = '0;
    low_phase(h);
    chk(h == 2, "R2 error reset width", h, 2);
    chk(trap_valid && trap_vec == exp, "R4 vector", trap_vec, exp);
    repeat (2) @(negedge clk);
    chk(trap_valid && trap_vec == exp, "R7 held while not ready", trap_vec, exp);
    accept();
    chk(!trap_valid, "R7 valid drops after handshake", trap_valid, 0);
  endtask

  task automatic t_collide();
    int h;
    @(negedge clk) begin ctl_err = 1; par_err = 1; mmu_abort = 1; end
    @(negedge clk) {ctl_err, par_err, mmu_abort} = '0;
    low_phase(h);
    chk(trap_vec == 9'o010, "R5 priority control wins", trap_vec, 9'o010);
    accept();
    low_phase(h);
    chk(h == 0 && !trap_valid, "R5 losers dropped", h, 0);
  endtask

  task automatic t_level();
    int h;
    @(negedge clk) bus_err = 1;
    low_phase(h);
    chk(h == 2 && trap_vec == 9'o004, "R6 held level served once", trap_vec, 9'o004);
    accept();
    low_phase(h);
    chk(h == 0, "R6 no second service for held level", h, 0);
    @(negedge clk) bus_err = 0;
  endtask

  task automatic t_backpressure();
    int h;
    @(negedge clk) par_err = 1;
    @(negedge clk) par_err = 0;
    low_phase(h);
    chk(trap_vec == 9'o114, "R8 first vector", trap_vec, 9'o114);
    @(negedge clk) mmu_abort = 1;
    @(negedge clk) mmu_abort = 0;
    low_phase(h);
    chk(h == 0, "R8 no reset while vector waits", h, 0);
    chk(trap_vec == 9'o114, "R8 old vector kept", trap_vec, 9'o114);
    accept();
    low_phase(h);
    chk(h == 2 && trap_vec == 9'o250, "R8 waiting abort served", trap_vec, 9'o250);
    accept();
  endtask

  task automatic t_power_cancel();
    int h;
    @(negedge clk) dc_low = 1;
    @(negedge clk) dc_low = 0;
    @(negedge clk) dc_low = 1;
    @(negedge clk);
    low_phase(h);
    chk(h == 0, "R3 power loss cancels resets", h, 0);
    @(negedge clk) dc_low = 0;
    @(negedge clk) ctl_err = 1;
    @(negedge clk) ctl_err = 0;
    low_phase(h);
    chk(h == 2 && !trap_valid, "R5 power beats control", trap_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_powerup();
    t_vec(0, 9'o010);
    t_vec(1, 9'o004);
    t_vec(2, 9'o114);
    t_vec(3, 9'o250);
    t_collide();
    t_level();
    t_backpressure();
    t_power_cancel();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule